// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Sequencer

This block converts a single switching command and an enable into two gate-on requests: one for the high-side switch and one for the low-side switch of a half-bridge. It never lets the two requests overlap. A programmable dead interval, counted in cycles of the system clock, separates the two requests. The interval has separate lengths for the two switching directions. The low-side turn-on interval starts at the high-side turn-off command. The high-side turn-on interval starts once the low-side request has actually gone low.

Supervisory flags come from outside the block as synchronous digital levels. These are internal-supply undervoltage, a latched short-circuit fault, bootstrap-supply ready, and switch-node high. The first two, and a low enable, block both outputs at once; switching resumes by itself once they clear. The bootstrap-ready and switch-node-high flags act only as a permit for high-side turn-on. When neither is set, the block holds in an armed state with both switches off. It turns the high side on at the first cycle the permit appears.

The sequencer has six states:
- `ST_OFF`: blocked or just reset.
- `ST_LS_WAIT`: counting the dead time before low-side turn-on.
- `ST_LS_ON`: low side on.
- `ST_HS_WAIT`: counting the dead time before high-side turn-on.
- `ST_HS_ARMED`: dead time done, waiting for the permit.
- `ST_HS_ON`: high side on.

The transitions are:
- Any state goes to `ST_OFF` when blocked.
- `ST_OFF` goes to `ST_LS_WAIT` or `ST_HS_WAIT`, chosen by the command level.
- `ST_LS_WAIT` goes to `ST_LS_ON` when its timer expires.
- `ST_HS_WAIT` goes to `ST_HS_ON` when its timer expires with the permit present, and to `ST_HS_ARMED` when it expires without the permit.
- `ST_HS_ARMED` goes to `ST_HS_ON` when the permit appears.
- A low command moves any high-side state to `ST_LS_WAIT`.
- A high command moves any low-side state to `ST_HS_WAIT`.

Top module: `hb_gate_seq`

## Requirements
- R1: After reset both outputs are 0, and the first turn-on of either output happens only after its full dead interval has been counted from the first unblocked cycle.
- R2: With the command low and the block unblocked, `hs_on` is 0 from the first clock edge after the change. `ls_on` rises after exactly `LS_DEAD_CYC` cycles with both outputs 0. This holds even when `boot_ok` is 0.
- R3: With the command high and the block unblocked, `ls_on` is 0 from the first clock edge after the change. `hs_on` rises after exactly `HS_DEAD_CYC` cycles of `ls_on` low, provided the permit is present.
- R4: The high side turns on only while `boot_ok` or `sw_high` is 1. When neither is 1 and the command is high, both outputs stay 0.
- R5: When the dead interval has elapsed and only the missing permit holds the high side back, `hs_on` is 1 at the first clock edge after `boot_ok` or `sw_high` rises.
- R6: While `enable` is 0, both outputs are 0 in the same cycle, whatever the command level.
- R7: While `vdd_uv` is 1, both outputs are 0. Switching resumes without any other action once it clears, starting with a full dead interval.
- R8: While `fault_latched` is 1, both outputs are 0.
- R9: A dead-interval count restarts from zero whenever its precondition is lost. This happens on a command reversal or on any blocking condition.
- R10: `hs_on` and `ls_on` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 1 | Switching command: 1 requests the high side, 0 requests the low side |
| enable | input | 1 | Active-high enable; 0 forces both outputs off |
| vdd_uv | input | 1 | Internal-supply undervoltage flag |
| fault_latched | input | 1 | Latched short-circuit fault flag |
| boot_ok | input | 1 | Bootstrap supply at operating voltage |
| sw_high | input | 1 | Switch node sensed high |
| hs_on | output | 1 | High-side gate-on request |
| ls_on | output | 1 | Low-side gate-on request |

## Verification
Several rules are checked by assertions on every cycle:
- The two outputs never overlap.
- Each turn-on is preceded by the other output being low.
- High-side turn-on happens only with a permit.
- Both outputs stay off in the cycle right after a block clears.
- The timers stay in range and restart when their run condition is lost.

Other behaviour can only be shown by the bench's scenarios:
- The exact length of each dead interval.
- The restart of a partly counted interval after a command reversal or an enable glitch.
- The immediate turn-on from the armed state when the bootstrap flag rises.
- The automatic resumption after undervoltage or fault.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_LS_WAIT  = 3'd1,
        ST_LS_ON    = 3'd2,
        ST_HS_WAIT  = 3'd3,
        ST_HS_ARMED = 3'd4,
        ST_HS_ON    = 3'd5
    } hb_state_t;

endpackage

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = run && (cnt == LAST);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R9
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/hb_guard.sv
module hb_guard (
    input  logic enable,
    input  logic vdd_uv,
    input  logic fault_latched,
    input  logic boot_ok,
    input  logic sw_high,
    output logic blocked,
    output logic hs_permit
);

    always_comb begin
        blocked   = !enable || vdd_uv || fault_latched;
        hs_permit = boot_ok || sw_high;
    end

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_pkg::*;
#(
    parameter int unsigned LS_DEAD_CYC = 8,
    parameter int unsigned HS_DEAD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_in,
    input  logic enable,
    input  logic vdd_uv,
    input  logic fault_latched,
    input  logic boot_ok,
    input  logic sw_high,
    output logic hs_on,
    output logic ls_on
);

    hb_state_t state, nxt;
    logic blocked, hs_permit;
    logic ls_run, hs_run, ls_expired, hs_expired;

    hb_guard u_guard (
        .enable       (enable),
        .vdd_uv       (vdd_uv),
        .fault_latched(fault_latched),
        .boot_ok      (boot_ok),
        .sw_high      (sw_high),
        .blocked      (blocked),
        .hs_permit    (hs_permit)
    );

    assign ls_run = (state == ST_LS_WAIT);
    assign hs_run = (state == ST_HS_WAIT);

    hb_dead_timer #(.LIMIT(LS_DEAD_CYC)) u_ls_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ls_run),
        .expired(ls_expired)
    );

    hb_dead_timer #(.LIMIT(HS_DEAD_CYC)) u_hs_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (hs_run),
        .expired(hs_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (blocked) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:      nxt = cmd_in ? ST_HS_WAIT : ST_LS_WAIT;
                ST_LS_WAIT:  nxt = cmd_in ? ST_HS_WAIT
                                          : (ls_expired ? ST_LS_ON : ST_LS_WAIT);
                ST_LS_ON:    nxt = cmd_in ? ST_HS_WAIT : ST_LS_ON;
                ST_HS_WAIT: begin
                    if (!cmd_in)         nxt = ST_LS_WAIT;
                    else if (hs_expired) nxt = hs_permit ? ST_HS_ON : ST_HS_ARMED;
                    else                 nxt = ST_HS_WAIT;
                end
                ST_HS_ARMED: nxt = !cmd_in ? ST_LS_WAIT
                                           : (hs_permit ? ST_HS_ON : ST_HS_ARMED);
                ST_HS_ON:    nxt = cmd_in ? ST_HS_ON : ST_LS_WAIT;
                default:     nxt = ST_OFF;
            endcase
        end
    end

    // Output decode
    always_comb begin
        hs_on = (state == ST_HS_ON) && !blocked;
        ls_on = (state == ST_LS_ON) && !blocked;
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R3
    hs_after_ls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(!ls_on));

    // R2
    ls_after_hs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> $past(!hs_on));

    // R4
    hs_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(boot_ok || sw_high));

    // R1
    unblock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked) |-> (!hs_on && !ls_on));

endmodule

// File: tb/hb_gate_seq_bench.sv
`timescale 1ns/1ps
module hb_gate_seq_bench;

    localparam int unsigned LS_D = 3;
    localparam int unsigned HS_D = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_in = 1'b0, enable = 1'b0, vdd_uv = 1'b0, fault_latched = 1'b0;
    logic boot_ok = 1'b0, sw_high = 1'b0;
    logic hs_on, ls_on;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  hs;
        logic  ls;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    hb_gate_seq #(.LS_DEAD_CYC(LS_D), .HS_DEAD_CYC(HS_D)) u_hb_gate_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_in       (cmd_in),
        .enable       (enable),
        .vdd_uv       (vdd_uv),
        .fault_latched(fault_latched),
        .boot_ok      (boot_ok),
        .sw_high      (sw_high),
        .hs_on        (hs_on),
        .ls_on        (ls_on)
    );

    // Driver: applies inputs at the falling edge, queues what the outputs
    // must be after the following rising edge.
    task automatic drive(input logic c, input logic e, input logic u, input logic f,
                         input logic b, input logic s, input int n,
                         input logic ehs, input logic els, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_in = c; enable = e; vdd_uv = u; fault_latched = f;
            boot_ok = b; sw_high = s;
            exp_q.push_back('{ehs, els, tag});
        end
    endtask

    // Monitor: compares one queued item per cycle, just after the edge.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (hs_on !== e.hs || ls_on !== e.ls) begin
                errors++;
                $display("FAIL %s: hs_on/ls_on = %b%b expected %b%b at %0t",
                         e.tag, hs_on, ls_on, e.hs, e.ls, $time);
            end
            checks++;
            if (hs_on === 1'b1 && ls_on === 1'b1) begin
                errors++;
                $display("FAIL R10: hs_on/ls_on = 11 expected not both 1 at %0t", $time);
            end
        end
    end

    initial begin
        // R1: reset state
        drive(0, 0, 0, 0, 0, 0, 3, 0, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: first low-side turn-on after full interval, boot not ready
        drive(0, 1, 0, 0, 0, 0, LS_D, 0, 0, "R1");
        drive(0, 1, 0, 0, 0, 0, 4, 0, 1, "R2");

        // R3: high-side turn-on after interval from low side going low
        drive(1, 1, 0, 0, 1, 0, HS_D, 0, 0, "R3");
        drive(1, 1, 0, 0, 1, 0, 3, 1, 0, "R3");

        // R2: back to low side
        drive(0, 1, 0, 0, 1, 0, LS_D, 0, 0, "R2");
        drive(0, 1, 0, 0, 1, 0, 2, 0, 1, "R2");

        // R4: no permit, both held off; R5: permit releases at once
        drive(1, 1, 0, 0, 0, 0, 10, 0, 0, "R4");
        drive(1, 1, 0, 0, 1, 0, 2, 1, 0, "R5");

        // R4: switch-node-high alone permits the high side
        drive(0, 1, 0, 0, 0, 0, LS_D, 0, 0, "R2");
        drive(0, 1, 0, 0, 0, 0, 1, 0, 1, "R2");
        drive(1, 1, 0, 0, 0, 1, HS_D, 0, 0, "R4");
        drive(1, 1, 0, 0, 0, 1, 2, 1, 0, "R4");

        // R6: enable low blocks in both command levels
        drive(1, 0, 0, 0, 0, 1, 3, 0, 0, "R6");
        drive(0, 0, 0, 0, 0, 0, 2, 0, 0, "R6");
        drive(0, 1, 0, 0, 0, 0, LS_D, 0, 0, "R6");
        drive(0, 1, 0, 0, 0, 0, 1, 0, 1, "R6");

        // R7: undervoltage blocks, then resumes with a full interval
        drive(0, 1, 1, 0, 0, 0, 3, 0, 0, "R7");
        drive(1, 1, 0, 0, 1, 0, HS_D, 0, 0, "R7");
        drive(1, 1, 0, 0, 1, 0, 2, 1, 0, "R7");

        // R8: latched fault blocks
        drive(1, 1, 0, 1, 1, 0, 2, 0, 0, "R8");
        drive(1, 1, 0, 0, 1, 0, HS_D, 0, 0, "R8");
        drive(1, 1, 0, 0, 1, 0, 1, 1, 0, "R8");

        // R9: command reversal mid-interval restarts the count
        drive(0, 1, 0, 0, 1, 0, 2, 0, 0, "R9");
        drive(1, 1, 0, 0, 1, 0, HS_D, 0, 0, "R9");
        drive(1, 1, 0, 0, 1, 0, 1, 1, 0, "R9");
        drive(0, 1, 0, 0, 1, 0, 2, 0, 0, "R9");
        drive(0, 0, 0, 0, 1, 0, 1, 0, 0, "R9");
        drive(0, 1, 0, 0, 1, 0, LS_D, 0, 0, "R9");
        drive(0, 1, 0, 0, 1, 0, 1, 0, 1, "R9");
        drive(1, 1, 0, 0, 1, 0, 3, 0, 0, "R9");
        drive(0, 1, 0, 0, 1, 0, LS_D, 0, 0, "R9");
        drive(0, 1, 0, 0, 1, 0, 2, 0, 1, "R10");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule